// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache

This block turns virtual addresses into physical addresses for a single-issue core. Instruction fetch, load and store all use the same lookup port. The cache is direct-mapped, and each entry holds one tag for each access kind. A kind gets its own tag only when the page grants that kind of access, so a hit needs nothing more than a tag compare and never needs a permission check.

A lookup that matches returns the physical address in the same cycle. A lookup that misses sends the virtual address to an external page-table walker and holds `busy_o` high until the walker returns a leaf entry. The block then picks the user or supervisor permission field according to the privilege mode captured with the request, checks the required permission and answers in the walker's response cycle. The answer is either a physical address or an access-fault cause. A fill happens only when the check passes. A flush input invalidates every tag in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: Pages are 4 KiB. The entry index is virtual address bits [15:12], taken modulo 16 entries. Two pages with the same index evict each other, and pages with different indices are kept side by side.
- R2: A lookup that matches the tag for its kind sets `resp_valid_o` in the same cycle, with `resp_fault_o` low, `busy_o` low, and `resp_paddr_o` equal to the installed frame address OR'd with vaddr[11:0].
- R3: A lookup that misses gives no response in its cycle. From the next cycle on, `busy_o` and `walk_req_o` stay high and `walk_vaddr_o` holds the request address, until the cycle in which `walk_done_i` is high. That cycle carries the response, and `busy_o` is low in the cycle after it.
- R4: Leaf entry layout. Bit 0 is the enable bit. Bits 1, 2 and 3 are the user read, write and execute permissions. Bits 4, 5 and 6 are the supervisor read, write and execute permissions. Bits 63:10 are the physical page number. The physical address is (ppn << 12) + offset, truncated to 64 bits. When `sup_mode_i` is high, bits 6:4 replace bits 3:1 as the effective permissions.
- R5: A load needs read, a store needs write and a fetch needs execute, and each of them also needs the enable bit. If any required bit is missing, the access faults and nothing is installed.
- R6: Fault causes on `resp_cause_o` are 1 for a fetch, 2 for a load and 3 for a store. A successful response reports 0. The kind codes on `req_kind_i` are 0 for load, 1 for store and 2 for fetch.
- R7: On a successful fill, the tag for each access kind is set only if the effective permission grants that kind. A later lookup of a kind that was not granted misses and walks again.
- R8: A flush invalidates every tag of every kind, and after it every lookup misses. This includes addresses in the topmost page, whose virtual page number is all ones.
- R9: When a flush falls in the same cycle as a walker response, the response is still delivered, but the flush wins and the entry is not installed.
- R10: After reset all entries are invalid, and `busy_o`, `walk_req_o` and `resp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| sup_mode_i | input | 1 | Supervisor privilege for the current request |
| req_valid_i | input | 1 | Lookup request (taken only when not busy) |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| req_vaddr_i | input | 64 | Virtual address |
| resp_valid_o | output | 1 | Response this cycle |
| resp_paddr_o | output | 64 | Physical address (0 on a fault) |
| resp_fault_o | output | 1 | Access fault |
| resp_cause_o | output | 2 | 0 none, 1 fetch, 2 load, 3 store fault |
| busy_o | output | 1 | Miss in progress |
| walk_req_o | output | 1 | Request to the page-table walker |
| walk_vaddr_o | output | 64 | Address to be walked |
| walk_done_i | input | 1 | Walker returns a leaf entry |
| walk_pte_i | input | 64 | Leaf entry from the walker |

## Verification
Two actions can collide in the same cycle: a flush and the fill that a walker response would trigger. The bench starts a miss, then raises `flush_i` in the very cycle it drives `walk_done_i`. It requires a correct translated response in that cycle. It then requires the next lookup of the same page to miss and walk again, which proves the flush discarded the fill. The sweep covers every combination of permissions, enable bit, privilege mode and access kind. For each combination the bench checks whether the first access faults and which of the three kinds hit afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned KIND_N = 3;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_FETCH = 2'd1;
  localparam logic [1:0] CAUSE_LOAD  = 2'd2;
  localparam logic [1:0] CAUSE_STORE = 2'd3;

  localparam int unsigned PTE_EN_BIT  = 0;
  localparam int unsigned PTE_USR_LSB = 1;  // r,w,x at 1..3
  localparam int unsigned PTE_SUP_LSB = 4;  // r,w,x at 4..6
  localparam int unsigned PTE_PPN_LSB = 10;

  // permission slot per kind: 0 read, 1 write, 2 execute; code 3 acts as load
  function automatic logic [1:0] kind_slot(logic [1:0] kind);
    return (kind == 2'd3) ? 2'd0 : kind;
  endfunction

  function automatic logic [1:0] kind_cause(logic [1:0] kind);
    case (kind)
      KIND_FETCH: return CAUSE_FETCH;
      KIND_STORE: return CAUSE_STORE;
      default:    return CAUSE_LOAD;
    endcase
  endfunction
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic [PTE_W-1:0]  pte_i,
  input  logic              sup_i,
  input  logic [1:0]        kind_i,
  output logic [KIND_N-1:0] grant_o,
  output logic              ok_o,
  output logic [1:0]        cause_o
);
  logic [KIND_N-1:0] usr_field;
  logic [KIND_N-1:0] sup_field;
  logic              en;

  assign usr_field = pte_i[PTE_USR_LSB +: KIND_N];
  assign sup_field = pte_i[PTE_SUP_LSB +: KIND_N];
  assign en        = pte_i[PTE_EN_BIT];

  // supervisor field moved onto user positions, gated by enable
  assign grant_o = (sup_i ? sup_field : usr_field) & {KIND_N{en}};
  assign ok_o    = grant_o[kind_slot(kind_i)];
  assign cause_o = ok_o ? CAUSE_NONE : kind_cause(kind_i);

  always_comb begin
    if (ok_o) AST_OK_NEEDS_ENABLE: assert (pte_i[PTE_EN_BIT]); // R5
  end
endmodule

// File: rtl/xlat_tag_array.sv
module xlat_tag_array
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 53,
  parameter int unsigned BASE_W  = 52,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          fill_i,
  input  logic [IDX_W-1:0]              fill_idx_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  input  logic [KIND_N-1:0]             fill_grant_i,
  input  logic [BASE_W-1:0]             fill_base_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  output logic [KIND_N-1:0][TAG_W-1:0]  rd_tags_o,
  output logic [BASE_W-1:0]             rd_base_o
);
  localparam logic [TAG_W-1:0] TAG_INV = '1;

  logic [BASE_W-1:0] base_q [ENTRIES];

  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    logic [TAG_W-1:0] tag_q [ENTRIES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < ENTRIES; i++) tag_q[i] <= TAG_INV;
      end else if (flush_i) begin
        for (int i = 0; i < ENTRIES; i++) tag_q[i] <= TAG_INV;
      end else if (fill_i) begin
        tag_q[fill_idx_i] <= fill_grant_i[k] ? fill_tag_i : TAG_INV;
      end
    end

    assign rd_tags_o[k] = tag_q[rd_idx_i];

    AST_FLUSH_BEATS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_i && fill_i) |=> (tag_q[$past(fill_idx_i)] == TAG_INV)); // R9
    AST_UNGRANTED_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fill_i && !flush_i && !fill_grant_i[k]) |=> (tag_q[$past(fill_idx_i)] == TAG_INV)); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) base_q[i] <= '0;
    end else if (fill_i && !flush_i) begin
      base_q[fill_idx_i] <= fill_base_i;
    end
  end

  assign rd_base_o = base_q[rd_idx_i];
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              hit_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              sup_i,
  input  logic              walk_done_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] walk_vaddr_o,
  output logic [1:0]        walk_kind_o,
  output logic              walk_sup_o
);
  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      walk_vaddr_o <= '0;
      walk_kind_o  <= KIND_LOAD;
      walk_sup_o   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i && !hit_i) begin
          state_q      <= ST_WALK;
          walk_vaddr_o <= req_vaddr_i;
          walk_kind_o  <= req_kind_i;
          walk_sup_o   <= sup_i;
        end
        default: if (walk_done_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_WALK);

  AST_BUSY_FROM_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i && !hit_i)); // R3
  AST_WALK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && walk_done_i) |=> !busy_o); // R3
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(walk_vaddr_o)); // R3
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ENTRIES    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              sup_mode_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              resp_valid_o,
  output logic [ADDR_W-1:0] resp_paddr_o,
  output logic              resp_fault_o,
  output logic [1:0]        resp_cause_o,
  output logic              busy_o,
  output logic              walk_req_o,
  output logic [ADDR_W-1:0] walk_vaddr_o,
  input  logic              walk_done_i,
  input  logic [ADDR_W-1:0] walk_pte_i
);
  localparam int unsigned VPN_W = ADDR_W - PAGE_SHIFT;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VPN_W + 1;  // top bit zero on valid tags

  logic [KIND_N-1:0][TAG_W-1:0] rd_tags;
  logic [VPN_W-1:0]             rd_base;
  logic [TAG_W-1:0]             req_tag;
  logic [TAG_W-1:0]             walk_tag;
  logic                         lookup_hit;
  logic                         walk_resp;
  logic                         fill;
  logic [1:0]                   walk_kind;
  logic                         walk_sup;
  logic [KIND_N-1:0]            grant;
  logic                         perm_ok;
  logic [1:0]                   perm_cause;
  logic [VPN_W-1:0]             walk_frame;
  logic [ADDR_W-1:0]            unused_pte;

  assign req_tag    = {1'b0, req_vaddr_i[ADDR_W-1:PAGE_SHIFT]};
  assign walk_tag   = {1'b0, walk_vaddr_o[ADDR_W-1:PAGE_SHIFT]};
  assign lookup_hit = (rd_tags[kind_slot(req_kind_i)] == req_tag);
  assign walk_frame = walk_pte_i[PTE_PPN_LSB +: VPN_W];
  assign unused_pte = walk_pte_i;

  xlat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .hit_i        (lookup_hit),
    .req_kind_i   (req_kind_i),
    .req_vaddr_i  (req_vaddr_i),
    .sup_i        (sup_mode_i),
    .walk_done_i  (walk_done_i),
    .busy_o       (busy_o),
    .walk_vaddr_o (walk_vaddr_o),
    .walk_kind_o  (walk_kind),
    .walk_sup_o   (walk_sup)
  );

  xlat_perm #(.PTE_W(ADDR_W)) u_perm (
    .pte_i   (walk_pte_i),
    .sup_i   (walk_sup),
    .kind_i  (walk_kind),
    .grant_o (grant),
    .ok_o    (perm_ok),
    .cause_o (perm_cause)
  );

  assign walk_resp = busy_o && walk_done_i;
  assign fill      = walk_resp && perm_ok;

  xlat_tag_array #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .BASE_W  (VPN_W)
  ) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .fill_i       (fill),
    .fill_idx_i   (walk_vaddr_o[PAGE_SHIFT +: IDX_W]),
    .fill_tag_i   (walk_tag),
    .fill_grant_i (grant),
    .fill_base_i  (walk_frame),
    .rd_idx_i     (req_vaddr_i[PAGE_SHIFT +: IDX_W]),
    .rd_tags_o    (rd_tags),
    .rd_base_o    (rd_base)
  );

  always_comb begin
    resp_valid_o = 1'b0;
    resp_fault_o = 1'b0;
    resp_cause_o = CAUSE_NONE;
    resp_paddr_o = '0;
    if (walk_resp) begin
      resp_valid_o = 1'b1;
      resp_fault_o = !perm_ok;
      resp_cause_o = perm_cause;
      if (perm_ok) resp_paddr_o = {walk_frame, walk_vaddr_o[PAGE_SHIFT-1:0]};
    end else if (!busy_o && req_valid_i && lookup_hit) begin
      resp_valid_o = 1'b1;
      resp_paddr_o = {rd_base, req_vaddr_i[PAGE_SHIFT-1:0]};
    end
  end

  assign walk_req_o = busy_o;

  AST_FLUSH_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lookup_hit); // R8
  AST_MISS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !lookup_hit) |-> !resp_valid_o); // R3
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> (resp_valid_o && resp_cause_o != CAUSE_NONE)); // R6
  AST_HIT_NEVER_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !walk_done_i) |-> !resp_fault_o); // R2
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        sup_mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = 2'd0;
  logic [63:0] req_vaddr_i = '0;
  logic        resp_valid_o;
  logic [63:0] resp_paddr_o;
  logic        resp_fault_o;
  logic [1:0]  resp_cause_o;
  logic        busy_o;
  logic        walk_req_o;
  logic [63:0] walk_vaddr_o;
  logic        walk_done_i = 1'b0;
  logic [63:0] walk_pte_i = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xlat_cache u_xlat_cache (
    .clk_i, .rst_ni, .flush_i, .sup_mode_i, .req_valid_i, .req_kind_i, .req_vaddr_i,
    .resp_valid_o, .resp_paddr_o, .resp_fault_o, .resp_cause_o, .busy_o,
    .walk_req_o, .walk_vaddr_o, .walk_done_i, .walk_pte_i
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_pa(logic [63:0] pte, logic [63:0] va);
    return ((pte >> 10) << 12) | (va & 64'hFFF);
  endfunction

  function automatic logic [1:0] exp_cause(logic [1:0] kind);
    return (kind == 2'd2) ? 2'd1 : (kind == 2'd1) ? 2'd3 : 2'd2;
  endfunction

  task automatic do_flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  // returns at the negedge after the request cycle
  task automatic issue(input logic [1:0] kind, input logic [63:0] va,
                       output bit hit, output logic [63:0] pa);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = kind; req_vaddr_i = va;
    #1;
    hit = resp_valid_o; pa = resp_paddr_o;
    if (hit) check(!resp_fault_o && !busy_o, "R2", "hit without fault", {63'd0, resp_fault_o}, 64'd0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!hit) begin
      check(busy_o && walk_req_o, "R3", "busy after miss", {63'd0, busy_o}, 64'd1);
      check(walk_vaddr_o == va, "R3", "walk address", walk_vaddr_o, va);
    end
  endtask

  task automatic reply(input logic [63:0] pte, input bit fl,
                       output bit fault, output logic [1:0] cause, output logic [63:0] pa);
    @(negedge clk_i);
    check(busy_o && !resp_valid_o, "R3", "busy held while waiting", {63'd0, busy_o}, 64'd1);
    walk_done_i = 1'b1; walk_pte_i = pte; flush_i = fl;
    #1;
    check(resp_valid_o, "R3", "response on walker cycle", {63'd0, resp_valid_o}, 64'd1);
    fault = resp_fault_o; cause = resp_cause_o; pa = resp_paddr_o;
    @(negedge clk_i);
    walk_done_i = 1'b0; flush_i = 1'b0;
    check(!busy_o, "R3", "busy released", {63'd0, busy_o}, 64'd0);
  endtask

  function automatic logic [63:0] make_pte(logic [63:0] ppn, logic [2:0] usr,
                                           logic [2:0] sup, bit en);
    return (ppn << 10) | (64'(sup) << 4) | (64'(usr) << 1) | 64'(en);
  endfunction

  initial begin
    bit hit, fault; logic [1:0] cause; logic [63:0] pa, pte, va_a, va_b, va_c;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check(!busy_o && !walk_req_o && !resp_valid_o, "R10", "idle after reset",
          {61'd0, busy_o, walk_req_o, resp_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !resp_valid_o, "R10", "idle after release", {63'd0, busy_o}, 64'd0);

    // R8/R10: topmost page must miss when invalid
    va_a = 64'hFFFF_FFFF_FFFF_F123;
    pte = make_pte(64'h3_ABCD, 3'b111, 3'b000, 1'b1);
    issue(2'd0, va_a, hit, pa);
    check(!hit, "R8", "all-ones page misses after reset", {63'd0, hit}, 64'd0);
    reply(pte, 1'b0, fault, cause, pa);
    check(!fault && pa == exp_pa(pte, va_a), "R4", "top page translation", pa, exp_pa(pte, va_a));
    issue(2'd0, va_a, hit, pa);
    check(hit && pa == exp_pa(pte, va_a), "R2", "top page hit", pa, exp_pa(pte, va_a));
    do_flush();
    issue(2'd0, va_a, hit, pa);
    check(!hit, "R8", "flush invalidates", {63'd0, hit}, 64'd0);
    reply(pte, 1'b0, fault, cause, pa);

    // sweep: mode x enable x permission field x first kind
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 8; p++)
          for (int k = 0; k < 3; k++) begin
            logic [2:0] eff; logic [63:0] va; bit installed; int n;
            n = ((s * 2 + e) * 8 + p) * 3 + k;
            sup_mode_i = s[0];
            eff = e[0] ? p[2:0] : 3'b000;
            va = 64'h0000_0ABC_0000_0000 | (64'(n) << 12) | 64'((n * 37) & 12'hFFF);
            pte = make_pte(64'h5_0000 + 64'(n), s[0] ? ~p[2:0] : p[2:0],
                           s[0] ? p[2:0] : ~p[2:0], e[0]);
            do_flush();
            issue(k[1:0], va, hit, pa);
            check(!hit, "R8", "miss after flush", {63'd0, hit}, 64'd0);
            reply(pte, 1'b0, fault, cause, pa);
            check(fault == !eff[k], "R5", "fault decision", {63'd0, fault}, {63'd0, !eff[k]});
            check(cause == (eff[k] ? 2'd0 : exp_cause(k[1:0])), "R6", "cause code",
                  64'(cause), 64'(eff[k] ? 2'd0 : exp_cause(k[1:0])));
            if (!fault) check(pa == exp_pa(pte, va), "R4", "walk translation", pa, exp_pa(pte, va));
            installed = !fault;
            for (int k2 = 0; k2 < 3; k2++) begin
              logic [63:0] va2;
              va2 = (va & ~64'hFFF) | 64'((k2 * 701 + 5) & 12'hFFF);
              issue(k2[1:0], va2, hit, pa);
              check(hit == (installed && eff[k2]), "R7", "per-kind tag", {63'd0, hit},
                    {63'd0, installed && eff[k2]});
              if (hit) check(pa == exp_pa(pte, va2), "R2", "hit address", pa, exp_pa(pte, va2));
              else begin
                reply(pte, 1'b0, fault, cause, pa);
                check(fault == !eff[k2], "R5", "refault decision", {63'd0, fault}, {63'd0, !eff[k2]});
                if (!fault) installed = 1'b1;
              end
            end
          end
    sup_mode_i = 1'b0;

    // R1: conflict in one index, coexistence across indices
    do_flush();
    va_a = 64'h0000_0000_0040_5010;
    va_b = 64'h0000_0000_0080_5020;
    va_c = 64'h0000_0000_0040_6030;
    pte = make_pte(64'h7_7000, 3'b111, 3'b000, 1'b1);
    issue(2'd0, va_a, hit, pa); reply(pte, 1'b0, fault, cause, pa);
    issue(2'd0, va_a, hit, pa);
    check(hit, "R1", "page A resident", {63'd0, hit}, 64'd1);
    issue(2'd0, va_b, hit, pa);
    check(!hit, "R1", "page B misses", {63'd0, hit}, 64'd0);
    reply(make_pte(64'h7_8000, 3'b111, 3'b000, 1'b1), 1'b0, fault, cause, pa);
    issue(2'd0, va_a, hit, pa);
    check(!hit, "R1", "page A evicted by same index", {63'd0, hit}, 64'd0);
    reply(pte, 1'b0, fault, cause, pa);
    issue(2'd1, va_c, hit, pa);
    reply(make_pte(64'h7_9000, 3'b111, 3'b000, 1'b1), 1'b0, fault, cause, pa);
    issue(2'd0, va_a, hit, pa);
    check(hit && pa == exp_pa(pte, va_a), "R1", "other index kept", pa, exp_pa(pte, va_a));

    // R9: flush in the walker response cycle
    do_flush();
    issue(2'd2, va_a, hit, pa);
    reply(pte, 1'b1, fault, cause, pa);
    check(!fault && pa == exp_pa(pte, va_a), "R9", "response kept under flush", pa, exp_pa(pte, va_a));
    issue(2'd2, va_a, hit, pa);
    check(!hit, "R9", "fill discarded by flush", {63'd0, hit}, 64'd0);
    reply(pte, 1'b0, fault, cause, pa);
    issue(2'd2, va_a, hit, pa);
    check(hit, "R9", "fill without flush sticks", {63'd0, hit}, 64'd1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule